// File: doc/BRIEF.md
# Ethernet Wake-Up Power Management Controller

This block sits beside the receive path of an Ethernet MAC and decides when received frames may reach the application. Software programs one 32-bit control/status word over a simple register bus. The word holds a power-down mode bit, three wake-source enables, two clear-on-read wake-cause flags and a self-clearing command that rewinds the wake-up filter pointer. Upstream detectors report their results as one-cycle pulses at the end of each frame. One pulse says a magic packet was seen. One says a wake-up frame pattern matched. One says a unicast frame passed the address filter. The block does not detect any of these itself.

While power-down is active, the block holds the forwarding enable low, so every received frame is dropped. An enabled detector pulse ends power-down by itself, records its cause and raises a one-cycle power-management event. The block also keeps the 3-bit pointer that the downstream filter logic uses to step through its wake-up pattern registers. It outputs a pulse when software rewinds that pointer.

Top module: `wake_pm_ctrl`

## Requirements
- R1: After reset the control/status word reads 0, the filter pointer is 0, the pointer-clear output is low and forwarding follows the frame-valid input.
- R2: Word bits 30:10, 8:7, 6:5 (by writes) and 4:3 are not writable. The reserved bits 30:10, 8:7 and 4:3 always read 0.
- R3: Writing bit 0 (power-down) as 1 sets power-down only when the same written word also has bit 1, bit 2 or bit 9 set. Otherwise power-down stays 0.
- R4: While power-down is 1, the forwarding output is 0. While it is 0, the forwarding output equals the frame-valid input.
- R5: A magic-packet pulse arriving while power-down and bit 1 (magic enable) are both 1 raises the event output in that same cycle. On the next edge it clears power-down and sets bit 5.
- R6: A wake-frame pulse with bit 2 set, or a unicast pulse with bit 9 set, arriving while power-down is 1, raises the event output in that cycle. On the next edge it clears power-down and sets bit 6.
- R7: A detector pulse has no effect while power-down is 0 or while its enable is 0. In that case there is no event, and power-down and the flags keep their values.
- R8: A read returns the flags (bits 5 and 6) as they stand and clears both of them at the end of the read cycle.
- R9: When a read and a flag-setting pulse fall in the same cycle, the flag is 1 afterwards.
- R10: Writing bit 0 as 0 clears power-down, so forwarding resumes without any wake event.
- R11: Each step pulse advances the 3-bit filter pointer by one, wrapping from 7 to 0.
- R12: Writing 1 to bit 31 sets the pointer to 0 on that edge, even if a step pulse arrives in the same cycle. Bit 31 and the pointer-clear output then read 1 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read (with reg_en) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control/status word |
| magic_pulse | input | 1 | Magic packet seen (one cycle) |
| wframe_pulse | input | 1 | Wake-up frame matched (one cycle) |
| ucast_pulse | input | 1 | Unicast frame passed address filter (one cycle) |
| ptr_step | input | 1 | Filter register access, advance pointer |
| rx_valid | input | 1 | Received frame offered for forwarding |
| rx_fwd | output | 1 | Frame may be forwarded to the application |
| pm_event | output | 1 | Power-management event (one cycle) |
| filt_ptr | output | PTR_W | Wake-up filter register pointer |
| filt_ptr_clr | output | 1 | Pointer was just rewound |

## Verification
Two pairs of functions can fall in the same cycle. A status read can coincide with a detector pulse that sets a flag. A pointer-rewind write can coincide with a step pulse. The bench provokes the first by reading while a qualifying magic pulse is present. It expects the old word on the bus in that cycle and the flag still set on the following read. For the second, it advances the pointer to a non-zero value, then writes bit 31 with a step pulse in the same cycle. It expects the pointer at 0 and the clear pulse high on the next cycle.

// File: rtl/wake_pm_pkg.sv
package wake_pm_pkg;
  localparam int REG_W   = 32;
  localparam int B_PD    = 0;
  localparam int B_EN_MP = 1;
  localparam int B_EN_WF = 2;
  localparam int B_MP_F  = 5;
  localparam int B_WF_F  = 6;
  localparam int B_GUC   = 9;
  localparam int B_PCLR  = 31;

  typedef struct packed {
    logic ptr_cmd;
    logic guc;
    logic wf_flag;
    logic mp_flag;
    logic en_wf;
    logic en_mp;
    logic pd;
  } wake_ctrl_t;

  function automatic logic [REG_W-1:0] pack_word(input wake_ctrl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_PD]    = c.pd;
    w[B_EN_MP] = c.en_mp;
    w[B_EN_WF] = c.en_wf;
    w[B_MP_F]  = c.mp_flag;
    w[B_WF_F]  = c.wf_flag;
    w[B_GUC]   = c.guc;
    w[B_PCLR]  = c.ptr_cmd;
    return w;
  endfunction

  function automatic logic pd_write_ok(input logic [REG_W-1:0] w);
    return w[B_PD] & (w[B_EN_MP] | w[B_EN_WF] | w[B_GUC]);
  endfunction

  function automatic logic [REG_W-1:0] reserved_mask();
    wake_ctrl_t all_on;
    all_on = '1;
    return ~pack_word(all_on);
  endfunction
endpackage

// File: rtl/wake_qualify.sv
module wake_qualify (
  input  logic pd,
  input  logic en_mp,
  input  logic en_wf,
  input  logic guc,
  input  logic magic_pulse,
  input  logic wframe_pulse,
  input  logic ucast_pulse,
  output logic mp_hit,
  output logic wf_hit,
  output logic wake
);
  always_comb begin
    mp_hit = pd & en_mp & magic_pulse;
    wf_hit = pd & ((en_wf & wframe_pulse) | (guc & ucast_pulse));
    wake   = mp_hit | wf_hit;
  end
endmodule

// File: rtl/wake_filt_ptr.sv
module wake_filt_ptr #(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             rewind,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (rewind) ptr <= '0;
    else if (step)   ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/wake_ctrl_reg.sv
module wake_ctrl_reg
  import wake_pm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [REG_W-1:0] wdata,
  input  logic             mp_hit,
  input  logic             wf_hit,
  output wake_ctrl_t       ctrl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (wr) begin
        ctrl.en_mp   <= wdata[B_EN_MP];
        ctrl.en_wf   <= wdata[B_EN_WF];
        ctrl.guc     <= wdata[B_GUC];
        ctrl.ptr_cmd <= wdata[B_PCLR];
      end else begin
        ctrl.ptr_cmd <= 1'b0;
      end

      if (mp_hit | wf_hit) ctrl.pd <= 1'b0;
      else if (wr)         ctrl.pd <= pd_write_ok(wdata);

      if (mp_hit)  ctrl.mp_flag <= 1'b1;
      else if (rd) ctrl.mp_flag <= 1'b0;

      if (wf_hit)  ctrl.wf_flag <= 1'b1;
      else if (rd) ctrl.wf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/wake_pm_ctrl.sv
module wake_pm_ctrl
  import wake_pm_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_en,
  input  logic             reg_we,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             magic_pulse,
  input  logic             wframe_pulse,
  input  logic             ucast_pulse,
  input  logic             ptr_step,
  input  logic             rx_valid,
  output logic             rx_fwd,
  output logic             pm_event,
  output logic [PTR_W-1:0] filt_ptr,
  output logic             filt_ptr_clr
);
  wake_ctrl_t ctrl;
  logic wr_stb, rd_stb, rewind_stb;
  logic mp_hit, wf_hit, wake;
  logic pd_bit;

  assign wr_stb     = reg_en & reg_we;
  assign rd_stb     = reg_en & ~reg_we;
  assign rewind_stb = wr_stb & reg_wdata[B_PCLR];
  assign pd_bit     = ctrl.pd;

  wake_qualify u_qual (
    .pd          (ctrl.pd),
    .en_mp       (ctrl.en_mp),
    .en_wf       (ctrl.en_wf),
    .guc         (ctrl.guc),
    .magic_pulse (magic_pulse),
    .wframe_pulse(wframe_pulse),
    .ucast_pulse (ucast_pulse),
    .mp_hit      (mp_hit),
    .wf_hit      (wf_hit),
    .wake        (wake)
  );

  wake_ctrl_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_stb),
    .rd    (rd_stb),
    .wdata (reg_wdata),
    .mp_hit(mp_hit),
    .wf_hit(wf_hit),
    .ctrl  (ctrl)
  );

  wake_filt_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (ptr_step),
    .rewind(rewind_stb),
    .ptr   (filt_ptr)
  );

  assign reg_rdata    = pack_word(ctrl);
  assign rx_fwd       = rx_valid & ~pd_bit;
  assign pm_event     = wake;
  assign filt_ptr_clr = ctrl.ptr_cmd;
endmodule

// File: rtl/wake_pm_ctrl_chk.sv
module wake_pm_ctrl_chk
  import wake_pm_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_stb,
  input logic             rd_stb,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             pd_bit,
  input logic             mp_hit,
  input logic             wf_hit,
  input logic             pm_event,
  input logic             rx_fwd,
  input logic [PTR_W-1:0] filt_ptr,
  input logic             filt_ptr_clr
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & reserved_mask()) == '0);

  p_pd_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && reg_wdata[B_PD] && !reg_wdata[B_EN_MP] && !reg_wdata[B_EN_WF]
     && !reg_wdata[B_GUC] && !pd_bit) |=> !pd_bit);

  p_fwd_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pd_bit |-> !rx_fwd);

  p_wake_clears_pd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pm_event |=> !pd_bit);

  p_event_needs_pd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pm_event |-> pd_bit);

  p_set_beats_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mp_hit && rd_stb) |=> reg_rdata[B_MP_F]);

  p_wf_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wf_hit |=> reg_rdata[B_WF_F]);

  p_rewind_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && reg_wdata[B_PCLR]) |=> (filt_ptr == '0 && filt_ptr_clr));

  p_clr_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_ptr_clr && !(wr_stb && reg_wdata[B_PCLR])) |=> !filt_ptr_clr);
endmodule

bind wake_pm_ctrl wake_pm_ctrl_chk #(.PTR_W(PTR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_stb      (wr_stb),
  .rd_stb      (rd_stb),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .pd_bit      (pd_bit),
  .mp_hit      (mp_hit),
  .wf_hit      (wf_hit),
  .pm_event    (pm_event),
  .rx_fwd      (rx_fwd),
  .filt_ptr    (filt_ptr),
  .filt_ptr_clr(filt_ptr_clr)
);

// File: tb/wake_pm_ctrl_tb.sv
module wake_pm_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic magic_pulse = 1'b0, wframe_pulse = 1'b0, ucast_pulse = 1'b0;
  logic ptr_step = 1'b0, rx_valid = 1'b0;
  logic rx_fwd, pm_event, filt_ptr_clr;
  logic [2:0] filt_ptr;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  typedef struct {
    logic [31:0] rd;
    logic        fwd;
    logic        evt;
    logic [2:0]  ptr;
    logic        clr;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  // reference state, from the requirements
  logic m_pd = 0, m_emp = 0, m_ewf = 0, m_guc = 0, m_mpf = 0, m_wff = 0, m_clr = 0;
  logic [2:0] m_ptr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_pm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .magic_pulse(magic_pulse), .wframe_pulse(wframe_pulse),
    .ucast_pulse(ucast_pulse), .ptr_step(ptr_step), .rx_valid(rx_valid),
    .rx_fwd(rx_fwd), .pm_event(pm_event), .filt_ptr(filt_ptr),
    .filt_ptr_clr(filt_ptr_clr)
  );

  // one cycle of stimulus; expected outputs come from the model
  task automatic cyc(input logic en, input logic we, input logic [31:0] wd,
                     input logic mg, input logic wf, input logic uc,
                     input logic st, input logic rxv, input string tag);
    exp_t e;
    logic hm, hw, wr, rd;
    @(negedge clk);
    reg_en = en; reg_we = we; reg_wdata = wd;
    magic_pulse = mg; wframe_pulse = wf; ucast_pulse = uc;
    ptr_step = st; rx_valid = rxv;
    hm = m_pd & m_emp & mg;
    hw = m_pd & ((m_ewf & wf) | (m_guc & uc));
    e.rd  = {m_clr, 21'b0, m_guc, 2'b0, m_wff, m_mpf, 2'b0, m_ewf, m_emp, m_pd};
    e.fwd = rxv & ~m_pd;
    e.evt = hm | hw;
    e.ptr = m_ptr;
    e.clr = m_clr;
    e.tag = tag;
    sb_q.push_back(e);
    wr = en & we;
    rd = en & ~we;
    @(posedge clk);
    if (wr && wd[31])  m_ptr = 3'd0;
    else if (st)       m_ptr = m_ptr + 3'd1;
    if (hm)      m_mpf = 1;
    else if (rd) m_mpf = 0;
    if (hw)      m_wff = 1;
    else if (rd) m_wff = 0;
    if (hm | hw)  m_pd = 0;
    else if (wr)  m_pd = wd[0] & (wd[1] | wd[2] | wd[9]);
    if (wr) begin
      m_emp = wd[1]; m_ewf = wd[2]; m_guc = wd[9]; m_clr = wd[31];
    end else m_clr = 0;
  endtask

  task automatic wr_w(input logic [31:0] d, input string tag);
    cyc(1, 1, d, 0, 0, 0, 0, 1, tag);
  endtask
  task automatic rd_w(input string tag);
    cyc(1, 0, '0, 0, 0, 0, 0, 1, tag);
  endtask
  task automatic pulse(input logic mg, input logic wf, input logic uc, input string tag);
    cyc(0, 0, '0, mg, wf, uc, 0, 1, tag);
  endtask

  // monitor: sample just before the rising edge
  always @(negedge clk) begin
    #(CLK_PERIOD/2 - 1);
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (reg_rdata !== e.rd || rx_fwd !== e.fwd || pm_event !== e.evt ||
          filt_ptr !== e.ptr || filt_ptr_clr !== e.clr) begin
        errors++;
        $display("FAIL %s: rd=%h fwd=%b evt=%b ptr=%0d clr=%b expected rd=%h fwd=%b evt=%b ptr=%0d clr=%b",
                 e.tag, reg_rdata, rx_fwd, pm_event, filt_ptr, filt_ptr_clr,
                 e.rd, e.fwd, e.evt, e.ptr, e.clr);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    rd_w("R1 reset word");
    cyc(0, 0, '0, 0, 0, 0, 0, 0, "R1 idle no frame");
    // R2 reserved and flag bits not writable
    wr_w(32'h7FFF_FDF8, "R2 write reserved");
    rd_w("R2 readback zero");
    // R3 power-down refused without enables
    wr_w(32'h0000_0001, "R3 pd alone");
    rd_w("R3 pd stays clear");
    // R4 / R6 / R7 wake frame path
    wr_w(32'h0000_0005, "R4 pd with wframe enable");
    cyc(0, 0, '0, 0, 0, 0, 0, 1, "R4 frame dropped");
    cyc(0, 0, '0, 0, 0, 0, 0, 0, "R4 no frame");
    pulse(1, 0, 1, "R7 disabled sources ignored");
    rd_w("R7 state unchanged");
    pulse(0, 1, 0, "R6 wframe wake");
    rd_w("R8 flag read");
    rd_w("R8 flag cleared");
    // R5 magic packet
    wr_w(32'h0000_0003, "R5 pd with magic enable");
    pulse(1, 0, 0, "R5 magic wake");
    rd_w("R5 flag set");
    rd_w("R8 magic flag cleared");
    // R6 global unicast
    wr_w(32'h0000_0201, "R6 pd with unicast");
    pulse(0, 0, 1, "R6 unicast wake");
    rd_w("R6 unicast flag");
    // R7 pulses while pd clear
    wr_w(32'h0000_0206, "R7 enables without pd");
    pulse(1, 1, 1, "R7 no pd no event");
    rd_w("R7 no flags");
    // R9 read with set in same cycle
    wr_w(32'h0000_0003, "R9 arm");
    cyc(1, 0, '0, 1, 0, 0, 0, 1, "R9 read during wake");
    rd_w("R9 flag survived");
    rd_w("R9 flag then cleared");
    // R10 software clear
    wr_w(32'h0000_0003, "R10 arm");
    wr_w(32'h0000_0002, "R10 software clear");
    cyc(0, 0, '0, 0, 0, 0, 0, 1, "R10 forwarding resumed");
    // R11 pointer wrap
    for (int i = 0; i < 9; i++) cyc(0, 0, '0, 0, 0, 0, 1, 0, "R11 step");
    cyc(0, 0, '0, 0, 0, 0, 0, 0, "R11 after wrap");
    // R12 rewind beats step
    cyc(0, 0, '0, 0, 0, 0, 1, 0, "R12 step");
    cyc(0, 0, '0, 0, 0, 0, 1, 0, "R12 step");
    cyc(1, 1, 32'h8000_0000, 0, 0, 0, 1, 1, "R12 rewind with step");
    cyc(0, 0, '0, 0, 0, 0, 0, 1, "R12 clear pulse");
    cyc(0, 0, '0, 0, 0, 0, 0, 1, "R12 clear ended");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule